// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 external interrupt pins and turns activity on them into interrupt requests for a downstream vectored interrupt controller. Each pin first passes through a synchroniser. A per-line trigger selection then decides whether the line reacts to a low level, a high level, a falling edge, a rising edge or either edge. A detected event sets the line's pending flag. Software clears a flag by writing a one to it.

A mask register blocks individual lines from reaching the outputs. Masking never changes the pending flags themselves. The unmasked pending flags are combined into four request outputs that cover unequal line ranges: one group of four lines and three groups of eight.

Software reaches the trigger, mask and pending state through a small word-addressed register bus. Writes are synchronous and reads are combinational. Each trigger selection is shared by a pair of neighbouring lines.

Top module: `grouped_eint_ctrl`

## Requirements
- R1: While reset is asserted, all of the following hold: every mask bit is 1, every pending flag is 0, both trigger registers read 0, and all four group outputs are 0.
- R2: The bus has four word addresses:
  - 0 holds the triggers for lines 0–15.
  - 1 holds the triggers for lines 16–27.
  - 2 is the mask register.
  - 3 is the pending register.

  Within a trigger register, the field for local line k is 3 bits wide and starts at bit (k/2)*4, so lines 2j and 2j+1 share one field. All other bits of a trigger register read as 0.
- R3: Trigger code 000 selects low level and code 001 selects high level. In a level mode, the pending flag is set on every cycle while the synchronised pin is at its active level.
- R4: Trigger codes 010 and 011 select falling edge. A high-to-low change sets the flag, and a low-to-high change does not.
- R5: Trigger codes 100 and 101 select rising edge. A low-to-high change sets the flag, and a high-to-low change does not.
- R6: Trigger codes 110 and 111 select both edges. Either change sets the flag.
- R7: Writing to address 3 clears each pending flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: When an event and a clear reach the same line in the same cycle, the flag ends up set.
- R9: At address 2, bit n set to 1 masks line n. Bits 0–27 are writable, and bits 28–31 read as 0.
- R10: A read of address 3 returns the pending flags as they are latched, whatever the mask holds.
- R11: Each group output is the OR of pending AND NOT mask over its line range. The ranges are:
  - group 0: lines 0–3
  - group 1: lines 4–11
  - group 2: lines 12–19
  - group 3: lines 20–27
- R12: A pin change applied between clock edges shows up in the pending register after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pins | input | 28 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_grp | output | 4 | Grouped interrupt requests |

## Verification
The bench builds the block with its default parameters: 28 lines, 16 lines in the first trigger register, a two-stage synchroniser and group starts at lines 4, 12 and 20. Because of these values, the bench can check the exact three-edge latency from pin to flag. It can also reach the group edges at lines 3/4 and 11/12, a field shared by lines 0 and 1, and the topmost line, 27, in the second trigger register. The unused upper register bits are observed through readback of all-ones writes.

// File: rtl/eint_pkg.sv
// Shared definitions for the grouped external interrupt controller.
// Assumes trigger fields are 3 bits on a 4-bit pitch, one per line pair.
package eint_pkg;

    typedef enum logic [1:0] {
        REG_CFG_LO = 2'd0,
        REG_CFG_HI = 2'd1,
        REG_MASK   = 2'd2,
        REG_PEND   = 2'd3
    } eint_reg_e;

    // Decide whether a line fires this cycle from its trigger code and samples.
    function automatic logic trig_hit(input logic [2:0] sel,
                                      input logic       cur,
                                      input logic       prev);
        logic hit;
        case (sel[2:1])
            2'b00:   hit = sel[0] ? cur : ~cur;
            2'b01:   hit = prev & ~cur;
            2'b10:   hit = ~prev & cur;
            default: hit = prev ^ cur;
        endcase
        return hit;
    endfunction

    // Writable-bit mask of a trigger register holding the given number of lines.
    function automatic logic [31:0] field_mask(input int lines);
        logic [31:0] m;
        m = '0;
        for (int k = 0; k < lines; k++) begin
            m[(k / 2) * 4 +: 3] = 3'b111;
        end
        return m;
    endfunction

endpackage

// File: rtl/eint_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no reset so the chain tracks pins during reset.
module eint_sync #(
    parameter int WIDTH  = 28,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pin samples through the flop chain.
    always_ff @(posedge clk) begin
        chain[0] <= d;
        for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/eint_detect.sv
// Per-line level and edge detection.
// Assumes lvl is already synchronised; the trigger field of local line k is
// at bit (k/2)*4 of the register that holds that line.
module eint_detect
    import eint_pkg::*;
#(
    parameter int LINES    = 28,
    parameter int LO_LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    input  logic [31:0]      cfg_lo,
    input  logic [31:0]      cfg_hi,
    output logic [LINES-1:0] evt
);

    logic [LINES-1:0] prev;
    logic             unused_cfg;

    // Keep the previous synchronised sample for edge comparison.
    always_ff @(posedge clk) begin
        prev <= lvl;
    end

    assign unused_cfg = ^{cfg_lo, cfg_hi};

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam int LOC = (i < LO_LINES) ? i : i - LO_LINES;
        localparam int SH  = (LOC / 2) * 4;
        logic [2:0] sel;

        if (i < LO_LINES) begin : g_lo
            assign sel = cfg_lo[SH +: 3];
        end else begin : g_hi
            assign sel = cfg_hi[SH +: 3];
        end

        assign evt[i] = trig_hit(sel, lvl[i], prev[i]);

        assert_fall_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[2:1] == 2'b01 && evt[i]) |-> (!lvl[i] && $past(lvl[i])));
        assert_rise_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[2:1] == 2'b10 && evt[i]) |-> (lvl[i] && !$past(lvl[i])));
        assert_any_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[2:1] == 2'b11 && evt[i]) |-> (lvl[i] != $past(lvl[i])));
    end

endmodule

// File: rtl/eint_regs.sv
// Register file: two trigger registers, mask, pending with write-one-to-clear.
// Assumes an event and a clear in the same cycle resolve to set.
module eint_regs
    import eint_pkg::*;
#(
    parameter int LINES    = 28,
    parameter int LO_LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    input  logic [LINES-1:0] evt,
    output logic [31:0]      rdata,
    output logic [31:0]      cfg_lo,
    output logic [31:0]      cfg_hi,
    output logic [LINES-1:0] mask_q,
    output logic [LINES-1:0] pend_q
);

    localparam logic [31:0] LO_WM = field_mask(LO_LINES);
    localparam logic [31:0] HI_WM = field_mask(LINES - LO_LINES);

    logic [LINES-1:0] clr;

    // Bus writes to trigger and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_lo <= '0;
            cfg_hi <= '0;
            mask_q <= '1;
        end else if (wr) begin
            case (eint_reg_e'(addr))
                REG_CFG_LO: cfg_lo <= wdata & LO_WM;
                REG_CFG_HI: cfg_hi <= wdata & HI_WM;
                REG_MASK:   mask_q <= wdata[LINES-1:0];
                default:    ;
            endcase
        end
    end

    assign clr = (wr && eint_reg_e'(addr) == REG_PEND) ? wdata[LINES-1:0] : '0;

    // Latch events into pending; set takes priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= evt | (pend_q & ~clr);
        end
    end

    // Combinational readback of the addressed register.
    always_comb begin
        rdata = '0;
        case (eint_reg_e'(addr))
            REG_CFG_LO: rdata = cfg_lo;
            REG_CFG_HI: rdata = cfg_hi;
            REG_MASK:   rdata[LINES-1:0] = mask_q;
            default:    rdata[LINES-1:0] = pend_q;
        endcase
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && mask_q == '1 && cfg_lo == '0 && cfg_hi == '0));
    assert_clear_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd3) |=> ((pend_q & $past(wdata[LINES-1:0]) & ~$past(evt)) == '0));
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> (($past(evt) & ~pend_q) == '0));
    assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 2'd2) |=> (mask_q == $past(wdata[LINES-1:0])));

endmodule

// File: rtl/grouped_eint_ctrl.sv
// Top: synchroniser, detector, register file and grouped request outputs.
// Assumes four groups bounded by GRP1_START, GRP2_START, GRP3_START, NUM_LINES.
module grouped_eint_ctrl #(
    parameter int NUM_LINES   = 28,
    parameter int LO_LINES    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int GRP1_START  = 4,
    parameter int GRP2_START  = 12,
    parameter int GRP3_START  = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_pins,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [3:0]           irq_grp
);

    localparam int NUM_GROUPS = 4;

    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] evt;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] live;
    logic [31:0]          cfg_lo;
    logic [31:0]          cfg_hi;

    eint_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (ext_pins),
        .q   (lvl)
    );

    eint_detect #(.LINES(NUM_LINES), .LO_LINES(LO_LINES)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (lvl),
        .cfg_lo (cfg_lo),
        .cfg_hi (cfg_hi),
        .evt    (evt)
    );

    eint_regs #(.LINES(NUM_LINES), .LO_LINES(LO_LINES)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .evt    (evt),
        .rdata  (bus_rdata),
        .cfg_lo (cfg_lo),
        .cfg_hi (cfg_hi),
        .mask_q (mask_q),
        .pend_q (pend_q)
    );

    assign live = pend_q & ~mask_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int GLO = (g == 0) ? 0 : (g == 1) ? GRP1_START :
                             (g == 2) ? GRP2_START : GRP3_START;
        localparam int GHI = (g == 0) ? GRP1_START - 1 : (g == 1) ? GRP2_START - 1 :
                             (g == 2) ? GRP3_START - 1 : NUM_LINES - 1;
        assign irq_grp[g] = |live[GHI:GLO];
    end

    assert_all_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> (irq_grp == 4'b0000));
    assert_no_group_without_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (irq_grp == 4'b0000));

endmodule

// File: tb/sim_grouped_eint_ctrl.sv
`timescale 1ns/1ps
module sim_grouped_eint_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [27:0] ext_pins;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_grp;

    always #2 clk = ~clk;

    grouped_eint_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pins  (ext_pins),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_grp   (irq_grp)
    );

    typedef struct {
        bit          is_grp;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // Monitor: pop expected items and compare with the sampled outputs.
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (sb.size() > 0);
            it  = sb.pop_front();
            act = it.is_grp ? {28'b0, irq_grp} : bus_rdata;
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk_reg(input logic [1:0] a, input logic [31:0] e, input string t);
        bus_addr = a;
        #0.5;
        sb.push_back('{1'b0, e, t});
        #0.5;
    endtask

    task automatic chk_grp(input logic [3:0] e, input string t);
        sb.push_back('{1'b1, {28'b0, e}, t});
        #0.5;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    // Driver: stimulus and expected values.
    initial begin
        rst_n = 1'b0; ext_pins = '1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
        settle(4);
        rst_n = 1'b1;
        chk_reg(2'd0, 32'h0, "R1 cfg_lo reset");
        chk_reg(2'd1, 32'h0, "R1 cfg_hi reset");
        chk_reg(2'd2, 32'h0FFF_FFFF, "R1 mask reset");
        chk_reg(2'd3, 32'h0, "R1 pending reset");
        chk_grp(4'b0000, "R1 groups reset");

        wr(2'd0, 32'hFFFF_FFFF); chk_reg(2'd0, 32'h7777_7777, "R2 cfg_lo layout");
        wr(2'd1, 32'hFFFF_FFFF); chk_reg(2'd1, 32'h0077_7777, "R2 cfg_hi layout");
        wr(2'd0, 32'h0000_0004); wr(2'd1, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF); chk_reg(2'd2, 32'h0FFF_FFFF, "R9 mask width");
        wr(2'd2, 32'h0);         chk_reg(2'd2, 32'h0, "R9 unmask all");

        // Rising edge on line 0 with latency check.
        ext_pins[0] = 1'b0; settle(3); chk_reg(2'd3, 32'h0, "R5 falling ignored");
        ext_pins[0] = 1'b1; settle(2); chk_reg(2'd3, 32'h0, "R12 not after two edges");
        settle(1); chk_reg(2'd3, 32'h1, "R12 R5 rise latched");
        chk_grp(4'b0001, "R11 group0 line0");
        wr(2'd3, 32'h0); chk_reg(2'd3, 32'h1, "R7 write zero kept");
        wr(2'd3, 32'h1); chk_reg(2'd3, 32'h0, "R7 write one clears");
        chk_grp(4'b0000, "R11 group0 cleared");

        // Line 1 shares field 0 with line 0.
        ext_pins[1] = 1'b0; settle(3); chk_reg(2'd3, 32'h0, "R2 shared field fall ignored");
        ext_pins[1] = 1'b1; settle(3); chk_reg(2'd3, 32'h2, "R2 shared field rise");
        wr(2'd3, 32'h2);

        // Falling edge on line 3.
        wr(2'd0, 32'h0000_0024);
        ext_pins[3] = 1'b0; settle(3); chk_reg(2'd3, 32'h8, "R4 fall latched");
        chk_grp(4'b0001, "R11 group0 line3");
        ext_pins[3] = 1'b1; settle(3); chk_reg(2'd3, 32'h8, "R4 rise ignored");
        wr(2'd3, 32'h8); chk_reg(2'd3, 32'h0, "R7 clear line3");

        // Both edges on line 5.
        wr(2'd0, 32'h0000_0624);
        ext_pins[5] = 1'b0; settle(3); chk_reg(2'd3, 32'h20, "R6 fall latched");
        chk_grp(4'b0010, "R11 group1 line5");
        wr(2'd3, 32'h20); chk_reg(2'd3, 32'h0, "R7 clear line5");
        ext_pins[5] = 1'b1; settle(3); chk_reg(2'd3, 32'h20, "R6 rise latched");
        wr(2'd3, 32'h20);

        // High level on lines 16 and 17 (shared field).
        wr(2'd1, 32'h0000_0001); settle(1);
        chk_reg(2'd3, 32'h0003_0000, "R3 high level latched");
        chk_grp(4'b0100, "R11 group2 lines16-17");
        wr(2'd3, 32'h0003_0000); chk_reg(2'd3, 32'h0003_0000, "R8 set wins over clear");
        ext_pins[16] = 1'b0; ext_pins[17] = 1'b0; settle(3);
        wr(2'd3, 32'h0003_0000); chk_reg(2'd3, 32'h0, "R3 clear after level drops");

        // Low level on line 27 with masking.
        ext_pins[27] = 1'b0; settle(3); chk_reg(2'd3, 32'h0800_0000, "R3 low level latched");
        chk_grp(4'b1000, "R11 group3 line27");
        wr(2'd2, 32'h0800_0000); chk_grp(4'b0000, "R9 mask blocks line27");
        chk_reg(2'd3, 32'h0800_0000, "R10 raw pending while masked");
        wr(2'd2, 32'h0); chk_grp(4'b1000, "R9 unmask restores");
        ext_pins[27] = 1'b1; settle(3);
        wr(2'd3, 32'h0800_0000); chk_reg(2'd3, 32'h0, "R7 clear line27");

        // Group boundary between lines 11 and 12.
        ext_pins[11] = 1'b0; ext_pins[12] = 1'b0; settle(3);
        chk_reg(2'd3, 32'h0000_1800, "R11 lines11-12 pending");
        chk_grp(4'b0110, "R11 boundary 11/12");
        ext_pins[11] = 1'b1; ext_pins[12] = 1'b1; settle(3);
        wr(2'd3, 32'h0000_1800); chk_reg(2'd3, 32'h0, "R7 clear 11-12");
        chk_grp(4'b0000, "R11 all quiet");

        wait (sb.size() == 0);
        #1;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule